// File: doc/BRIEF.md
# Banked Interrupt Aggregation Controller

This block gathers a parameterised number of peripheral interrupt lines and folds them into one interrupt pin toward a host processor. The lines are split into banks of 32. Every bank keeps, per line, an enable bit, a raw status bit and a capture-mode bit. Each line is either level sensitive, so the status simply follows the input, or rising-edge sensitive, so the status is latched until software clears it. All incoming lines pass through a synchronizer before any capture logic sees them.

Software reaches the controller through a single-cycle memory-mapped bus. Reads return data in the same cycle as the request. Writes take effect at the next clock edge. Two global gates sit in front of the output pin. A master enable lets software configure the controller without stray requests reaching the pin. A separate output enable lets an interrupt handler silence the pin while it services a request, without losing any pending status. A read-only identification word reports how many lines exist and which version of the controller is built. A global pending bit shows whether any enabled line is active, even while both gates are closed.

Top module: `irq_bank_aggregator`

## Requirements
- R1: The word at byte address 0x000 is read-only. Bits [15:0] return NUM_LINES and bits [31:16] return VERSION. The defaults read 0x0A03_0040. Elaboration rejects a VERSION of 0x0000 or 0xFFFF, and a NUM_LINES that is zero or not a multiple of 32.
- R2: There are NUM_LINES/32 banks. Bank b occupies byte addresses 0x100 + 0x20*b onward, and bit i of every bank register belongs to line 32*b + i.
- R3: Writing bank offset +0x00 sets every enable bit whose data bit is 1 and leaves the enable bits whose data bit is 0 unchanged. Reads of offset +0x00 and of offset +0x04 both return the current enables.
- R4: Writing bank offset +0x04 clears every enable bit whose data bit is 1, so writing 0xFFFFFFFF disables the whole bank.
- R5: Bank offset +0x0C is a read/write capture-mode word: 0 selects level and 1 selects rising edge. For a level line, raw status equals the synchronized input. Writing 1 to that line's raw-clear bit leaves its raw status unchanged.
- R6: An edge line sets its raw status on a rising edge of the synchronized input. The status then holds until a 1 is written to its bit at bank offset +0x08. With SYNC_STAGES=2, a line change shows in raw status after the third rising clock edge. If a capture and a clear of the same bit fall on the same edge, the capture wins. A line held high does not set the bit again.
- R7: Reading bank offset +0x08 returns raw status. Reading bank offset +0x10 returns raw status AND enable, and writes to offset +0x10 have no effect.
- R8: Bit 0 of address 0x008 is 1 exactly when any bit of any bank's raw-AND-enable is 1. This holds regardless of the master enable and the output enable. The other bits of this word read 0.
- R9: Address 0x004 bit 0 is the master enable and address 0x00C bit 0 is the output enable; both read back. irq_out is registered: one edge after the state changes, it equals master enable AND output enable AND the bit described in R8.
- R10: Reads of undefined offsets, of banks at or beyond NUM_LINES/32, and of any address while bus_sel is low return 0. Writes to undefined offsets or missing banks change no state.
- R11: After reset, every enable, raw status, mode bit, the master enable, the output enable and irq_out are 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low reset: asserts asynchronously, releases in step with clk |
| bus_sel | input | 1 | Bus access request for this cycle |
| bus_wr | input | 1 | 1 = write, 0 = read |
| bus_addr | input | ADDR_W | Byte address, word aligned |
| bus_wdata | input | 32 | Write data |
| bus_rdata | output | 32 | Read data, valid in the request cycle |
| irq_lines | input | NUM_LINES | Asynchronous peripheral interrupt lines |
| irq_out | output | 1 | Aggregated interrupt toward the host |

## Verification
The sharpest collision is a raw-status clear write landing on the same edge at which an edge line's synchronized rising edge is captured. The bench raises the line exactly two cycles before the clear write, so the write edge is the capture edge. It then expects the bit to survive the clear, and expects a second clear to remove it while the line stays high. A second overlap checks that status keeps building while the output is masked. Lines change while the output enable or the master enable is being toggled, and a behavioural model compares irq_out with its own prediction on every clock. Long pseudo-random runs mix line activity with set, clear, mode and gate writes. They compare every read against the model, so that coincidences nobody scheduled are judged as well.

// File: rtl/irqagg_pkg.sv
package irqagg_pkg;

  // Number of lines handled by one bank.
  localparam int unsigned LANES = 32;

  // Global word offsets (bytes).
  localparam int unsigned OFS_ID    = 'h000;
  localparam int unsigned OFS_MEN   = 'h004;
  localparam int unsigned OFS_MSTAT = 'h008;
  localparam int unsigned OFS_OEN   = 'h00C;

  // Bank window.
  localparam int unsigned OFS_BANK0 = 'h100;

  // Offsets inside one bank (bank stride is 32 bytes).
  localparam logic [4:0] FLD_EN_SET = 5'h00;
  localparam logic [4:0] FLD_EN_CLR = 5'h04;
  localparam logic [4:0] FLD_RAW    = 5'h08;
  localparam logic [4:0] FLD_MODE   = 5'h0C;
  localparam logic [4:0] FLD_MASKED = 5'h10;

  // Per-bank write strobes produced by the address decoder.
  typedef struct packed {
    logic en_set;
    logic en_clr;
    logic raw_clr;
    logic mode_wr;
  } bank_wr_t;

endpackage

// File: rtl/irqagg_sync.sv
module irqagg_sync #(
  parameter int unsigned WIDTH  = 64,
  parameter int unsigned STAGES = 2
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic [WIDTH-1:0] async_in,
  output logic [WIDTH-1:0] sync_out
);

  logic [STAGES-1:0][WIDTH-1:0] chain_q;
  logic [STAGES-1:0][WIDTH-1:0] chain_d;

  always_comb begin
    chain_d[0] = async_in;
    for (int s = 1; s < STAGES; s++) begin
      chain_d[s] = chain_q[s-1];
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      chain_q <= '0;
    end else begin
      chain_q <= chain_d;
    end
  end

  assign sync_out = chain_q[STAGES-1];

endmodule

// File: rtl/irqagg_bank.sv
module irqagg_bank
  import irqagg_pkg::*;
(
  input  logic             clk,
  input  logic             rst_n,
  input  bank_wr_t         wr,
  input  logic [LANES-1:0] wdata,
  input  logic [LANES-1:0] line_s,
  output logic [LANES-1:0] en_q,
  output logic [LANES-1:0] raw_q,
  output logic [LANES-1:0] mode_q,
  output logic [LANES-1:0] masked
);

  logic [LANES-1:0] prev_q;
  logic [LANES-1:0] en_d;
  logic [LANES-1:0] raw_d;
  logic [LANES-1:0] mode_d;
  logic [LANES-1:0] rise;
  logic [LANES-1:0] clr_mask;
  logic             en_ce;
  logic             mode_ce;

  // Next-state logic.
  always_comb begin
    rise     = line_s & ~prev_q;
    clr_mask = wr.raw_clr ? wdata : '0;

    en_ce = wr.en_set | wr.en_clr;
    en_d  = en_q;
    if (wr.en_set) en_d = en_d | wdata;
    if (wr.en_clr) en_d = en_d & ~wdata;

    mode_ce = wr.mode_wr;
    mode_d  = wdata;

    // Edge lines: sticky, capture beats clear. Level lines: follow input.
    raw_d = (mode_q & ((raw_q & ~clr_mask) | rise)) | (~mode_q & line_s);
  end

  // State registers.
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      en_q   <= '0;
      mode_q <= '0;
      raw_q  <= '0;
      prev_q <= '0;
    end else begin
      if (en_ce)   en_q   <= en_d;
      if (mode_ce) mode_q <= mode_d;
      raw_q  <= raw_d;
      prev_q <= line_s;
    end
  end

  assign masked = raw_q & en_q;

  // Set strobe turns on every requested enable.
  assert_en_set_R3: assert property (@(posedge clk) disable iff (!rst_n)
    wr.en_set |=> ((en_q & $past(wdata)) == $past(wdata)));

  // Clear strobe turns off every requested enable.
  assert_en_clr_R4: assert property (@(posedge clk) disable iff (!rst_n)
    wr.en_clr |=> ((en_q & $past(wdata)) == '0));

  // Level lines mirror the synchronized input one edge later.
  assert_level_follow_R5: assert property (@(posedge clk) disable iff (!rst_n)
    1'b1 |=> ((~$past(mode_q) & (raw_q ^ $past(line_s))) == '0));

  // Latched edge status survives unless its bit was cleared.
  assert_edge_hold_R6: assert property (@(posedge clk) disable iff (!rst_n)
    1'b1 |=> (($past(mode_q & raw_q & ~clr_mask) & ~raw_q) == '0));

  // A fresh edge is always captured, even against a same-edge clear.
  assert_edge_wins_R6: assert property (@(posedge clk) disable iff (!rst_n)
    1'b1 |=> (($past(mode_q & line_s & ~prev_q) & ~raw_q) == '0));

endmodule

// File: rtl/irqagg_outgate.sv
module irqagg_outgate
  import irqagg_pkg::*;
#(
  parameter int unsigned NUM_BANKS = 2
) (
  input  logic                            clk,
  input  logic                            rst_n,
  input  logic [NUM_BANKS-1:0][LANES-1:0] masked,
  input  logic                            master_en,
  input  logic                            out_en,
  output logic                            pending,
  output logic                            irq_q
);

  logic irq_d;

  always_comb begin
    pending = |masked;
    irq_d   = master_en & out_en & pending;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      irq_q <= 1'b0;
    end else begin
      irq_q <= irq_d;
    end
  end

endmodule

// File: rtl/irq_bank_aggregator.sv
module irq_bank_aggregator
  import irqagg_pkg::*;
#(
  parameter int unsigned NUM_LINES   = 64,
  parameter logic [15:0] VERSION     = 16'h0A03,
  parameter int unsigned ADDR_W      = 12,
  parameter int unsigned SYNC_STAGES = 2
) (
  input  logic                 clk,
  input  logic                 rst_n,
  input  logic                 bus_sel,
  input  logic                 bus_wr,
  input  logic [ADDR_W-1:0]    bus_addr,
  input  logic [31:0]          bus_wdata,
  output logic [31:0]          bus_rdata,
  input  logic [NUM_LINES-1:0] irq_lines,
  output logic                 irq_out
);

  localparam int unsigned NUM_BANKS = NUM_LINES / LANES;
  localparam int unsigned IDX_W     = ADDR_W - 5;
  localparam logic [ADDR_W-1:0] A_ID    = ADDR_W'(OFS_ID);
  localparam logic [ADDR_W-1:0] A_MEN   = ADDR_W'(OFS_MEN);
  localparam logic [ADDR_W-1:0] A_MSTAT = ADDR_W'(OFS_MSTAT);
  localparam logic [ADDR_W-1:0] A_OEN   = ADDR_W'(OFS_OEN);
  localparam logic [ADDR_W-1:0] A_BANK0 = ADDR_W'(OFS_BANK0);
  localparam logic [IDX_W-1:0]  NB_IDX  = IDX_W'(NUM_BANKS);
  localparam logic [15:0]       NL16    = 16'(NUM_LINES);

  // Elaboration-time parameter checks.
  if (VERSION == 16'h0000 || VERSION == 16'hFFFF) begin : g_bad_version
    $error("irq_bank_aggregator: VERSION must not be 0x0000 or 0xFFFF");
  end
  if (NUM_LINES == 0 || (NUM_LINES % LANES) != 0) begin : g_bad_lines
    $error("irq_bank_aggregator: NUM_LINES must be a nonzero multiple of 32");
  end

  // ---------------------------------------------------------------------
  // Address decode
  // ---------------------------------------------------------------------
  logic              wr_en;
  logic              rd_en;
  logic [ADDR_W-1:0] bank_off;
  logic [IDX_W-1:0]  bank_idx;
  logic [4:0]        field;
  logic              bank_hit;
  logic              field_ok;
  logic              glob_hit;
  logic              any_hit;

  always_comb begin
    wr_en    = bus_sel & bus_wr;
    rd_en    = bus_sel & ~bus_wr;
    bank_off = bus_addr - A_BANK0;
    bank_idx = bank_off[ADDR_W-1:5];
    field    = bank_off[4:0];
    bank_hit = (bus_addr >= A_BANK0) && (bank_idx < NB_IDX);
    field_ok = (field == FLD_EN_SET) || (field == FLD_EN_CLR) ||
               (field == FLD_RAW)    || (field == FLD_MODE)   ||
               (field == FLD_MASKED);
    glob_hit = (bus_addr == A_ID) || (bus_addr == A_MEN) ||
               (bus_addr == A_MSTAT) || (bus_addr == A_OEN);
    any_hit  = glob_hit || (bank_hit && field_ok);
  end

  // ---------------------------------------------------------------------
  // Global gates
  // ---------------------------------------------------------------------
  logic men_q, men_d, men_ce;
  logic oen_q, oen_d, oen_ce;

  always_comb begin
    men_ce = wr_en && (bus_addr == A_MEN);
    men_d  = bus_wdata[0];
    oen_ce = wr_en && (bus_addr == A_OEN);
    oen_d  = bus_wdata[0];
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      men_q <= 1'b0;
      oen_q <= 1'b0;
    end else begin
      if (men_ce) men_q <= men_d;
      if (oen_ce) oen_q <= oen_d;
    end
  end

  // ---------------------------------------------------------------------
  // Synchronizer and banks
  // ---------------------------------------------------------------------
  logic [NUM_LINES-1:0]            line_s;
  logic [NUM_BANKS-1:0][LANES-1:0] en_all;
  logic [NUM_BANKS-1:0][LANES-1:0] raw_all;
  logic [NUM_BANKS-1:0][LANES-1:0] mode_all;
  logic [NUM_BANKS-1:0][LANES-1:0] msk_all;
  bank_wr_t [NUM_BANKS-1:0]        bank_wr;

  irqagg_sync #(
    .WIDTH  (NUM_LINES),
    .STAGES (SYNC_STAGES)
  ) sync_i (
    .clk      (clk),
    .rst_n    (rst_n),
    .async_in (irq_lines),
    .sync_out (line_s)
  );

  for (genvar b = 0; b < NUM_BANKS; b++) begin : g_bank
    logic sel_b;
    assign sel_b = wr_en && bank_hit && (bank_idx == IDX_W'(b));
    assign bank_wr[b].en_set  = sel_b && (field == FLD_EN_SET);
    assign bank_wr[b].en_clr  = sel_b && (field == FLD_EN_CLR);
    assign bank_wr[b].raw_clr = sel_b && (field == FLD_RAW);
    assign bank_wr[b].mode_wr = sel_b && (field == FLD_MODE);

    irqagg_bank bank_i (
      .clk    (clk),
      .rst_n  (rst_n),
      .wr     (bank_wr[b]),
      .wdata  (bus_wdata),
      .line_s (line_s[b*LANES +: LANES]),
      .en_q   (en_all[b]),
      .raw_q  (raw_all[b]),
      .mode_q (mode_all[b]),
      .masked (msk_all[b])
    );
  end

  // ---------------------------------------------------------------------
  // Aggregation and output gating
  // ---------------------------------------------------------------------
  logic pending;

  irqagg_outgate #(
    .NUM_BANKS (NUM_BANKS)
  ) gate_i (
    .clk       (clk),
    .rst_n     (rst_n),
    .masked    (msk_all),
    .master_en (men_q),
    .out_en    (oen_q),
    .pending   (pending),
    .irq_q     (irq_out)
  );

  // ---------------------------------------------------------------------
  // Read mux
  // ---------------------------------------------------------------------
  always_comb begin
    bus_rdata = '0;
    if (rd_en) begin
      if (bus_addr == A_ID) begin
        bus_rdata = {VERSION, NL16};
      end else if (bus_addr == A_MEN) begin
        bus_rdata = {31'b0, men_q};
      end else if (bus_addr == A_MSTAT) begin
        bus_rdata = {31'b0, pending};
      end else if (bus_addr == A_OEN) begin
        bus_rdata = {31'b0, oen_q};
      end else if (bank_hit) begin
        for (int b = 0; b < NUM_BANKS; b++) begin
          if (bank_idx == IDX_W'(b)) begin
            case (field)
              FLD_EN_SET: bus_rdata = en_all[b];
              FLD_EN_CLR: bus_rdata = en_all[b];
              FLD_RAW:    bus_rdata = raw_all[b];
              FLD_MODE:   bus_rdata = mode_all[b];
              FLD_MASKED: bus_rdata = msk_all[b];
              default:    bus_rdata = '0;
            endcase
          end
        end
      end
    end
  end

  // ---------------------------------------------------------------------
  // Assertions
  // ---------------------------------------------------------------------
  // Closing the output enable silences the pin once the register settles.
  assert_oen_mask_R9: assert property (@(posedge clk) disable iff (!rst_n)
    (wr_en && (bus_addr == A_OEN) && !bus_wdata[0]) |=> ##1 !irq_out);

  // Closing the master enable silences the pin as well.
  assert_men_mask_R9: assert property (@(posedge clk) disable iff (!rst_n)
    (wr_en && (bus_addr == A_MEN) && !bus_wdata[0]) |=> ##1 !irq_out);

  // Idle bus reads as zero.
  assert_idle_rdata_R10: assert property (@(posedge clk) disable iff (!rst_n)
    !bus_sel |-> (bus_rdata == '0));

  // Writes to holes leave all configuration state untouched.
  assert_hole_write_R10: assert property (@(posedge clk) disable iff (!rst_n)
    (wr_en && !any_hit) |=> ($stable(men_q) && $stable(oen_q) &&
                             $stable(en_all) && $stable(mode_all)));

endmodule

// File: tb/irq_bank_aggregator_tb_top.sv
`timescale 1ns/1ps
module irq_bank_aggregator_tb_top;

  localparam int NL = 64;
  localparam logic [15:0] VER = 16'h0A03;

  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        bus_sel = 1'b0;
  logic        bus_wr = 1'b0;
  logic [11:0] bus_addr = '0;
  logic [31:0] bus_wdata = '0;
  logic [31:0] bus_rdata;
  logic [NL-1:0] irq_lines = '0;
  logic        irq_out;

  int n_cmp = 0;
  int n_bad = 0;
  bit run = 1'b0;
  bit done = 1'b0;

  always #4 clk = ~clk;  // 125 MHz

  irq_bank_aggregator #(
    .NUM_LINES   (NL),
    .VERSION     (VER),
    .ADDR_W      (12),
    .SYNC_STAGES (2)
  ) dut_i (
    .clk       (clk),
    .rst_n     (rst_n),
    .bus_sel   (bus_sel),
    .bus_wr    (bus_wr),
    .bus_addr  (bus_addr),
    .bus_wdata (bus_wdata),
    .bus_rdata (bus_rdata),
    .irq_lines (irq_lines),
    .irq_out   (irq_out)
  );

  // ---------------- behavioural reference model ----------------
  logic [NL-1:0] m_s1, m_s2, m_prev, m_raw, m_en, m_mode;
  logic          m_me, m_oe, m_irq;

  always @(posedge clk or negedge rst_n) begin
    logic [NL-1:0] clr, nen, nmode, nraw;
    logic          nme, noe;
    int a, bk, of;
    if (!rst_n) begin
      m_s1 <= '0; m_s2 <= '0; m_prev <= '0; m_raw <= '0;
      m_en <= '0; m_mode <= '0; m_me <= 1'b0; m_oe <= 1'b0; m_irq <= 1'b0;
    end else begin
      clr = '0; nen = m_en; nmode = m_mode; nme = m_me; noe = m_oe;
      if (bus_sel && bus_wr) begin
        a = int'(bus_addr);
        if (a == 4) nme = bus_wdata[0];
        if (a == 12) noe = bus_wdata[0];
        if (a >= 256 && a < 256 + 32 * (NL / 32)) begin
          bk = (a - 256) / 32;
          of = (a - 256) % 32;
          for (int i = 0; i < 32; i++) begin
            if (of == 0 && bus_wdata[i]) nen[bk*32+i] = 1'b1;
            if (of == 4 && bus_wdata[i]) nen[bk*32+i] = 1'b0;
            if (of == 8) clr[bk*32+i] = bus_wdata[i];
            if (of == 12) nmode[bk*32+i] = bus_wdata[i];
          end
        end
      end
      for (int i = 0; i < NL; i++) begin
        if (m_mode[i]) nraw[i] = (m_raw[i] && !clr[i]) || (m_s2[i] && !m_prev[i]);
        else           nraw[i] = m_s2[i];
      end
      m_irq  <= m_me && m_oe && ((m_raw & m_en) != '0);
      m_raw  <= nraw;
      m_en   <= nen;
      m_mode <= nmode;
      m_me   <= nme;
      m_oe   <= noe;
      m_prev <= m_s2;
      m_s2   <= m_s1;
      m_s1   <= irq_lines;
    end
  end

  function automatic logic [31:0] mread(input int a);
    int bk, of;
    if (a == 0)  return {VER, 16'(NL)};
    if (a == 4)  return {31'b0, m_me};
    if (a == 8)  return {31'b0, ((m_raw & m_en) != '0)};
    if (a == 12) return {31'b0, m_oe};
    if (a >= 256 && a < 256 + 32 * (NL / 32)) begin
      bk = (a - 256) / 32;
      of = (a - 256) % 32;
      case (of)
        0, 4: return m_en[bk*32 +: 32];
        8:    return m_raw[bk*32 +: 32];
        12:   return m_mode[bk*32 +: 32];
        16:   return m_raw[bk*32 +: 32] & m_en[bk*32 +: 32];
        default: return 32'h0;
      endcase
    end
    return 32'h0;
  endfunction

  // ---------------- checking helpers ----------------
  task automatic chk(input string tag, input logic [31:0] got, input logic [31:0] exp);
    n_cmp++;
    if (got !== exp) begin
      n_bad++;
      $display("FAIL %s: got 0x%08h expected 0x%08h at %0t", tag, got, exp, $time);
    end
  endtask

  // Output pin compared against the model on every clock.
  always @(negedge clk) begin
    if (run) chk("R9 per-cycle irq_out", {31'b0, irq_out}, {31'b0, m_irq});
  end

  task automatic wr(input int a, input logic [31:0] d);
    @(negedge clk);
    bus_sel = 1'b1; bus_wr = 1'b1; bus_addr = 12'(a); bus_wdata = d;
  endtask

  task automatic rd_model(input int a, input string tag);
    @(negedge clk);
    bus_sel = 1'b1; bus_wr = 1'b0; bus_addr = 12'(a);
    #1;
    chk(tag, bus_rdata, mread(a));
  endtask

  task automatic rdx(input int a, input logic [31:0] exp, input string tag);
    @(negedge clk);
    bus_sel = 1'b1; bus_wr = 1'b0; bus_addr = 12'(a);
    #1;
    chk(tag, bus_rdata, exp);
  endtask

  task automatic idle(input int n);
    repeat (n) begin
      @(negedge clk);
      bus_sel = 1'b0; bus_wr = 1'b0;
    end
  endtask

  task automatic lines_set(input logic [NL-1:0] v);
    @(negedge clk);
    bus_sel = 1'b0; bus_wr = 1'b0; irq_lines = v;
  endtask

  task automatic pin_chk(input logic exp, input string tag);
    #1;
    chk(tag, {31'b0, irq_out}, {31'b0, exp});
  endtask

  // ---------------- watchdog ----------------
  initial begin
    repeat (100000) @(posedge clk);
    if (!done) begin
      n_cmp++;
      n_bad++;
      $display("FAIL watchdog: got timeout expected completion");
      $display("  *** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
      $finish;
    end
  end

  // ---------------- stimulus ----------------
  logic [31:0] lf;

  initial begin
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    run = 1'b1;
    idle(2);

    // R11 reset state, R1 identification
    chk("R11 irq_out after reset", {31'b0, irq_out}, 32'h0);
    rdx('h000, 32'h0A03_0040, "R1 id word");
    rdx('h004, 32'h0, "R11 master enable reset");
    rdx('h008, 32'h0, "R11 master status reset");
    rdx('h00C, 32'h0, "R11 output enable reset");
    rdx('h100, 32'h0, "R11 bank0 enable reset");
    rdx('h108, 32'h0, "R11 bank0 raw reset");
    rdx('h10C, 32'h0, "R11 bank0 mode reset");
    rdx('h130, 32'h0, "R11 R2 bank1 masked reset");

    // R3 / R4 enable set and clear
    wr('h100, 32'h0000_00FF);
    rdx('h100, 32'hFF, "R3 enable set readback");
    rdx('h104, 32'hFF, "R3 enable via clear offset");
    wr('h100, 32'h0);
    rdx('h100, 32'hFF, "R3 zero bits no effect");
    wr('h104, 32'h0F);
    rdx('h100, 32'hF0, "R4 partial clear");
    wr('h104, 32'hFFFF_FFFF);
    rdx('h100, 32'h0, "R4 whole bank clear");
    wr('h100, 32'h0000_00FF);

    // R5 level capture
    lines_set(64'h1);
    idle(3);
    rdx('h108, 32'h1, "R5 level raw follows input");
    rdx('h008, 32'h1, "R8 pending with gates closed");
    pin_chk(1'b0, "R9 pin low with gates closed");
    wr('h108, 32'h1);
    rdx('h108, 32'h1, "R5 clear on held level ignored");
    lines_set(64'h0);
    idle(3);
    rdx('h108, 32'h0, "R5 level raw falls");

    // R6 edge capture
    wr('h10C, 32'h30);
    rdx('h10C, 32'h30, "R5 mode readback");
    lines_set(64'h10);
    lines_set(64'h0);
    idle(4);
    rdx('h108, 32'h10, "R6 edge latched after pulse");
    rdx('h110, 32'h10, "R7 masked status");
    wr('h108, 32'h10);
    rdx('h108, 32'h0, "R6 edge cleared");

    // R6 capture and clear on the same edge
    lines_set(64'h20);
    idle(1);
    wr('h108, 32'h20);
    rdx('h108, 32'h20, "R6 capture beats same-edge clear");
    wr('h108, 32'h20);
    rdx('h108, 32'h0, "R6 held line does not retrigger");
    lines_set(64'h0);
    idle(3);

    // R8 / R9 gating
    lines_set(64'h4);
    idle(3);
    rdx('h008, 32'h1, "R8 pending from level line");
    wr('h004, 32'h1);
    wr('h00C, 32'h1);
    idle(2);
    pin_chk(1'b1, "R9 pin high with both gates open");
    wr('h00C, 32'h0);
    idle(2);
    pin_chk(1'b0, "R9 output enable masks pin");
    rdx('h008, 32'h1, "R8 pending kept while masked");
    wr('h00C, 32'h1);
    idle(2);
    pin_chk(1'b1, "R9 output re-enabled");
    wr('h004, 32'h0);
    idle(2);
    pin_chk(1'b0, "R9 master enable masks pin");
    wr('h004, 32'h1);
    rdx('h004, 32'h1, "R9 master enable readback");
    rdx('h00C, 32'h1, "R9 output enable readback");

    // R2 / R7 second bank
    lines_set(64'h4 | (64'h1 << 40));
    idle(3);
    rdx('h128, 32'h100, "R2 R7 bank1 raw");
    rdx('h130, 32'h0, "R7 masked zero while disabled");
    wr('h120, 32'h100);
    rdx('h130, 32'h100, "R7 bank1 masked");
    wr('h130, 32'hFFFF_FFFF);
    rdx('h130, 32'h100, "R7 masked word write ignored");

    // R10 holes
    wr('h140, 32'hFFFF_FFFF);
    rdx('h140, 32'h0, "R10 missing bank reads zero");
    wr('h114, 32'hFFFF);
    rdx('h114, 32'h0, "R10 undefined bank offset");
    wr('h010, 32'hFFFF_FFFF);
    rdx('h010, 32'h0, "R10 undefined global");
    rdx('h100, 32'hFF, "R10 bank0 enable untouched");
    rdx('h10C, 32'h30, "R10 bank0 mode untouched");
    rdx('h120, 32'h100, "R10 bank1 enable untouched");
    @(negedge clk);
    bus_sel = 1'b0; bus_wr = 1'b0; bus_addr = 12'h000;
    #1;
    chk("R10 idle bus reads zero", bus_rdata, 32'h0);

    // Pseudo-random mix compared to the model
    lf = 32'h1D2C_3B4A;
    for (int it = 0; it < 1500; it++) begin
      int bk;
      lf = {lf[30:0], lf[31] ^ lf[21] ^ lf[1] ^ lf[0]};
      if (lf[9:8] == 2'b00) lines_set({lf, lf ^ 32'h5A5A_A5A5});
      lf = {lf[30:0], lf[31] ^ lf[21] ^ lf[1] ^ lf[0]};
      bk = lf[3] ? 1 : 0;
      case (lf[2:0])
        3'd0: wr(256 + 32*bk + 0,  {lf[15:0], lf[31:16]});
        3'd1: wr(256 + 32*bk + 4,  lf & 32'h0F0F_0F0F);
        3'd2: wr(256 + 32*bk + 8,  lf);
        3'd3: wr(256 + 32*bk + 12, lf ^ 32'h3333_3333);
        3'd4: wr(4,  {31'b0, lf[5] | lf[6]});
        3'd5: wr(12, {31'b0, lf[7] | lf[4]});
        default: begin
          case (lf[6:4])
            3'd0: rd_model(8, "R8 random master status");
            3'd1: rd_model(256 + 32*bk + 8, "R5 R6 random raw");
            3'd2: rd_model(256 + 32*bk + 16, "R7 random masked");
            3'd3: rd_model(256 + 32*bk + 0, "R3 random enable");
            3'd4: rd_model(256 + 32*bk + 4, "R4 random enable");
            3'd5: rd_model(256 + 32*bk + 12, "R5 random mode");
            default: rd_model(256 + 32*bk + 8, "R6 random raw");
          endcase
        end
      endcase
    end
    idle(4);

    done = 1'b1;
    run = 1'b0;
    $display("  *** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
    $finish;
  end

endmodule